// File: doc/BRIEF.md
# Dual-Clock Serial-to-Parallel Shift and Hold Register

This block turns a serial bit stream into a parallel word. A chain of `WIDTH` flip-flops takes one bit from `ser_in` on every rising edge of `shift_clk`. The newest bit enters stage 0 and every older bit moves one stage along. A separate hold register, clocked by `store_clk`, takes a snapshot of the whole chain in one step and drives `par_out`. The chain can keep filling while the parallel word stays steady. `par_out` only changes when the host decides to publish a new word.

The last stage of the chain drives `ser_out`. Several instances can be chained by feeding one instance's `ser_out` into the next instance's `ser_in`, which builds a longer word from one serial line. Each register has its own asynchronous active-low clear. A clear acts only on its own register.

If both clocks are driven by the same net, each pulse advances the chain and publishes the contents the chain held just before that pulse. The parallel word therefore runs exactly one pulse behind the chain.

Top module: `sipo_dual_reg`

## Requirements
- R1: On each rising edge of `shift_clk` while `shift_clr_n` is high, stage 0 takes `ser_in` and each stage n+1 takes the value stage n held before the edge.
- R2: `ser_out` always equals the last stage (`WIDTH-1`). After a shift edge it therefore shows the value that stage `WIDTH-2` held before that edge.
- R3: On a rising edge of `store_clk` while `store_clr_n` is high, the hold register takes a copy of every stage in parallel. Bit n of `par_out` comes from stage n, where stage 0 holds the most recently shifted bit.
- R4: While `shift_clr_n` is low, every stage and `ser_out` are 0. This takes effect at once, with no clock edge, and wins over any `shift_clk` edge. `par_out` is not affected.
- R5: While `store_clr_n` is low, `par_out` is 0. This takes effect at once and wins over any `store_clk` edge. The chain and `ser_out` are not affected.
- R6: A `store_clk` edge that follows a shift clear, with no shift edge in between, loads all zeros into `par_out`.
- R7: When both clocks rise at the same instant, `par_out` receives the chain contents from before that edge, while the chain itself advances by one bit.
- R8: With one instance's `ser_out` wired to a second instance's `ser_in`, 2*`WIDTH` shift edges place the first-shifted bit in stage `WIDTH-1` of the second instance. The pair then acts as a single 2*`WIDTH`-bit chain.
- R9: The register width is set by the parameter `WIDTH`, which defaults to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Clock of the shift chain; acts on its rising edge |
| shift_clr_n | input | 1 | Asynchronous active-low clear of the shift chain |
| store_clk | input | 1 | Clock of the hold register; acts on its rising edge |
| store_clr_n | input | 1 | Asynchronous active-low clear of the hold register |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Serial data out of the last stage, used for cascading |
| par_out | output | WIDTH | Parallel word from the hold register |

## Verification
The assertions in the RTL check, on every shift edge, that the chain advances by one position (R1) and that the cascade output is the old value of stage `WIDTH-2` (R2). They also check that each register reads zero whenever its own clear is low at a clock edge (R4, R5).

Some behaviours involve both registers, or two instances, or the order in which clocks and clears are applied. These are shown only by the bench scenarios:
- the parallel copy (R3) and the zero load after a shift clear (R6);
- the one-pulse lag when the clocks are tied (R7);
- each clear leaving the other register untouched (R4, R5);
- the 16-bit cascade of two instances (R8).

// File: rtl/sipo_pkg.sv
// Package: shared constants for the serial-to-parallel shift/hold register.
// Assumes: nothing; holds only the default width used by the top level.
package sipo_pkg;
    parameter int SIPO_DEFAULT_WIDTH = 8;
endpackage

// File: rtl/sipo_shift_chain.sv
// Module: serial-in shift chain with asynchronous active-low clear.
// Stage 0 takes ser_in; stage n+1 takes stage n on each rising shift_clk.
// Assumes: clear is released away from shift_clk edges (recovery time).
module sipo_shift_chain #(
    parameter int WIDTH = 8
) (
    input  logic             shift_clk,
    input  logic             shift_clr_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stages
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] next_stage;

    // Next value of each stage: the serial bit, then the stage below.
    assign next_stage = {stages[LAST-1:0], ser_in};

    // One flop per stage, each cleared asynchronously.
    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        always_ff @(posedge shift_clk or negedge shift_clr_n) begin
            if (!shift_clr_n)
                stages[g] <= 1'b0;
            else
                stages[g] <= next_stage[g];
        end
    end

    // Checker state: set once a shift edge has occurred with the clear released.
    logic armed;
    always_ff @(posedge shift_clk or negedge shift_clr_n) begin
        if (!shift_clr_n)
            armed <= 1'b0;
        else
            armed <= 1'b1;
    end

    assert_shift_advance_R1: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
        armed |-> stages[LAST:1] == $past(stages[LAST-1:0]));

    assert_tail_follows_R2: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
        armed |-> stages[LAST] == $past(stages[LAST-1]));

    assert_shift_clear_R4: assert property (@(posedge shift_clk)
        !shift_clr_n |-> stages == '0);
endmodule

// File: rtl/sipo_hold_reg.sv
// Module: parallel hold register with asynchronous active-low clear.
// On each rising store_clk it copies d in one step; q drives the outputs.
// Assumes: d is steady around store_clk edges (shift-to-store ordering is
// kept by the user; the two clocks are not synchronised here).
module sipo_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             store_clk,
    input  logic             store_clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Snapshot of the shift chain, cleared asynchronously.
    always_ff @(posedge store_clk or negedge store_clr_n) begin
        if (!store_clr_n)
            q <= '0;
        else
            q <= d;
    end

    assert_hold_clear_R5: assert property (@(posedge store_clk)
        !store_clr_n |-> q == '0);
endmodule

// File: rtl/sipo_dual_reg.sv
// Module: top level of the dual-clock serial-to-parallel register.
// A shift chain on shift_clk feeds a hold register on store_clk; the last
// stage is brought out as ser_out for cascading.
// Assumes: each clear is released away from its own clock edge.
module sipo_dual_reg #(
    parameter int WIDTH = sipo_pkg::SIPO_DEFAULT_WIDTH
) (
    input  logic             shift_clk,
    input  logic             shift_clr_n,
    input  logic             store_clk,
    input  logic             store_clr_n,
    input  logic             ser_in,
    output logic             ser_out,
    output logic [WIDTH-1:0] par_out
);
    logic [WIDTH-1:0] chain;

    sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .shift_clk   (shift_clk),
        .shift_clr_n (shift_clr_n),
        .ser_in      (ser_in),
        .stages      (chain)
    );

    sipo_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .store_clk   (store_clk),
        .store_clr_n (store_clr_n),
        .d           (chain),
        .q           (par_out)
    );

    // Cascade output: the last stage of the chain.
    assign ser_out = chain[WIDTH-1];

    assert_serout_cleared_R4: assert property (@(posedge shift_clk)
        !shift_clr_n |-> ser_out == 1'b0);
endmodule

// File: tb/sim_sipo_dual_reg.sv
`timescale 1ns/1ps
// Bench: two cascaded instances, u0 feeding u1, against an arithmetic model.
module sim_sipo_dual_reg;
    localparam int W = 8;

    logic base_clk = 1'b0;
    always #2 base_clk = ~base_clk;   // 250 MHz time base

    logic shift_clk = 1'b0, store_clk = 1'b0;
    logic shift_clr_n = 1'b1, store_clr_n = 1'b1;
    logic din = 1'b0;
    logic so0, so1;
    logic [W-1:0] po0, po1;

    sipo_dual_reg #(.WIDTH(W)) u0 (
        .shift_clk(shift_clk), .shift_clr_n(shift_clr_n),
        .store_clk(store_clk), .store_clr_n(store_clr_n),
        .ser_in(din), .ser_out(so0), .par_out(po0));

    sipo_dual_reg #(.WIDTH(W)) u1 (
        .shift_clk(shift_clk), .shift_clr_n(shift_clr_n),
        .store_clk(store_clk), .store_clr_n(store_clr_n),
        .ser_in(so0), .ser_out(so1), .par_out(po1));

    int checks = 0;
    int errors = 0;
    logic [2*W-1:0] m_chain = '0;   // model of both chains, bit 0 newest
    logic [2*W-1:0] m_hold  = '0;   // model of {po1, po0}

    task automatic check(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bit(logic b);
        din = b;
        #1 shift_clk = 1'b1;
        #1 shift_clk = 1'b0;
        m_chain = {m_chain[2*W-2:0], b};
        #1;
    endtask

    task automatic store_pulse();
        #1 store_clk = 1'b1;
        #1 store_clk = 1'b0;
        m_hold = m_chain;
        #1;
    endtask

    task automatic tied_pulse(logic b);
        din = b;
        #1;
        shift_clk = 1'b1;
        store_clk = 1'b1;
        #1;
        shift_clk = 1'b0;
        store_clk = 1'b0;
        m_hold  = m_chain;
        m_chain = {m_chain[2*W-2:0], b};
        #1;
    endtask

    task automatic check_all(string req);
        check(req, {po1, po0}, m_hold);
        check(req, {{(2*W-2){1'b0}}, so1, so0}, {{(2*W-2){1'b0}}, m_chain[2*W-1], m_chain[W-1]});
    endtask

    initial begin
        repeat (200000) @(posedge base_clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Reset: both clears asserted, including a clock edge held off by them (R4, R5).
        #1 shift_clr_n = 1'b0;
        store_clr_n = 1'b0;
        #1;
        shift_bit(1'b1);
        m_chain = '0;
        store_pulse();
        m_hold = '0;
        check_all("R4 R5 reset");
        #1 shift_clr_n = 1'b1;
        store_clr_n = 1'b1;
        #1;

        // Sweep of 16-bit patterns through the cascade (R1 R2 R3 R8 R9).
        for (int i = 0; i < 64; i++) begin
            logic [2*W-1:0] pat;
            pat = 16'(i * 1031) ^ 16'hA5C3;
            for (int k = 2*W-1; k >= 0; k--) begin
                shift_bit(pat[k]);
                check_all("R1 R2 shift");
            end
            store_pulse();
            check("R8 cascade", {po1, po0}, pat);
            check_all("R3 store");
        end

        // Shift clear: async, chain and ser_out to 0, hold untouched (R4).
        shift_clr_n = 1'b0;
        #1;
        m_chain = '0;
        check_all("R4 async clear");
        shift_bit(1'b1);
        m_chain = '0;
        check_all("R4 priority");
        #1 shift_clr_n = 1'b1;
        #1;

        // A store edge after the shift clear loads zeros (R6).
        store_pulse();
        check("R6 zero load", {po1, po0}, '0);

        // Store clear: hold to 0, chain untouched, then a reload proves it (R5).
        for (int k = 0; k < 2*W; k++)
            shift_bit(k[0] ^ k[2]);
        store_pulse();
        check_all("R3 reload");
        store_clr_n = 1'b0;
        #1;
        m_hold = '0;
        check_all("R5 async clear");
        store_pulse();
        m_hold = '0;
        check_all("R5 priority");
        #1 store_clr_n = 1'b1;
        #1;
        store_pulse();
        check_all("R5 chain kept");

        // Tied clocks: the hold register lags the chain by one pulse (R7).
        for (int k = 0; k < 3*W; k++) begin
            tied_pulse(k[1] ^ k[0] ^ k[3]);
            check_all("R7 tied lag");
        end
        store_pulse();
        check_all("R7 catch up");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule